// File: doc/BRIEF.md
# Transient Operand Chain Detector

This block watches retired instructions in program order and looks for values that live only briefly. Such a value is written by an ALU instruction and read by exactly one later ALU instruction before its register is written again. The block links each such producer and its single consumer, and it grows these links into short linear chains with no fan-out. Each chain that ends is sent out as one record for a chain cache, which lies outside this block.

There is one table entry for each architectural register. An entry holds the chain that ends in that register's current value, a saturating count of readers, whether the first reader was chainable, and the register the first reader wrote. A link is settled only when the register holding the value is overwritten. Chain members need not be adjacent in the stream, and they may lie in different basic blocks.

Both streams use valid/ready. An instruction is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only when no records are waiting to go out, so a single instruction can produce up to three records and these drain one per cycle under `out_ready`. A record that is offered stays unchanged until it is taken.

Top module: `transient_chain_detector`

## Requirements
- R1: After reset every table entry is empty, `out_valid` is 0 and `in_ready` is 1.
- R2: While any record is waiting, `in_ready` is 0 and no instruction is taken.
- R3: While `out_valid` is 1 and `out_ready` is 0, every output field stays unchanged.
- R4: When an ALU instruction with a destination writes register d, it becomes a one-member chain in entry d. A value in d is confirmed as transient when d is overwritten, d had exactly one reader, and that reader was an ALU instruction with a destination. On confirmation the reader's chain is appended after the chain held for d.
- R5: When an append brings a chain to three members, the chain is emitted at once and the entry receiving it becomes empty.
- R6: A second read of a value ends its chain. The chain is emitted if it has two or more members and is then discarded.
- R7: A read by an instruction that is not an ALU instruction, or by one with no destination, ends the chain of the value it reads in the same way as R6.
- R8: When a register is overwritten without a confirmed link, its chain is emitted if it has two or more members. A one-member chain is dropped silently.
- R9: A reader whose chain already has more than one member refuses a second predecessor. The producer's chain is then treated as in R8.
- R10: If the single reader's destination is overwritten before the producer's register, the link is lost and the producer's chain is treated as in R8.
- R11: When one instruction triggers several emissions, they leave in this order: from the source-0 read, from the source-1 read, then from the destination overwrite. A source that names the same register as source 0 counts as one read.
- R12: A record carries the first member's PC and `out_len` (2 or 3). Member k sits at bits [4k+3:4k] of `out_op`, `out_dst`, `out_src0` and `out_src1`, with member 0 the oldest. Slots past the length are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Retired instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| in_pc | input | 32 | Instruction PC |
| in_alu | input | 1 | Instruction is an ALU operation |
| in_op | input | 4 | Opcode class |
| in_dst_v | input | 1 | Destination register present |
| in_dst | input | 4 | Destination register index |
| in_src0_v | input | 1 | Source 0 present |
| in_src0 | input | 4 | Source 0 register index |
| in_src1_v | input | 1 | Source 1 present |
| in_src1 | input | 4 | Source 1 register index |
| out_valid | output | 1 | Chain record offered |
| out_ready | input | 1 | Chain record accepted |
| out_pc | output | 32 | PC of the oldest member |
| out_len | output | 2 | Member count |
| out_op | output | 12 | Opcode class per member |
| out_dst | output | 12 | Destination index per member |
| out_src0 | output | 12 | Source 0 index per member |
| out_src1 | output | 12 | Source 1 index per member |

## Verification
Read-side disqualification and write-side chain ending can both happen in the same instruction. A load-like instruction that reads two registers holding two-member chains, and that overwrites a third such register, triggers all three emissions at once. The bench offers that instruction while `out_ready` is held low. It then checks that `in_ready` stays low, that the first record stays unchanged, and that after release the three records arrive in the order source 0, source 1, overwrite. The appending overwrite and a second read of a chain's new tail are also driven in nearby instructions, so that stale links are exposed as records with the wrong length.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  localparam int NREG  = 16;
  localparam int RW    = $clog2(NREG);
  localparam int PCW   = 32;
  localparam int OPW   = 4;
  localparam int CMAX  = 3;
  localparam int LW    = $clog2(CMAX + 1);
  localparam int NEMIT = 3;
  localparam int CW    = $clog2(NEMIT + 1);

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [RW-1:0]  dst;
    logic [RW-1:0]  s0;
    logic [RW-1:0]  s1;
  } member_t;

  typedef struct packed {
    logic [PCW-1:0]         pc;
    logic [LW-1:0]          len;
    member_t [CMAX-1:0]     m;
  } chain_t;

  typedef struct packed {
    chain_t         ch;
    logic [1:0]     cnt;
    logic           rd_ok;
    logic [RW-1:0]  rd_dst;
  } entry_t;

  typedef struct packed {
    logic [PCW-1:0] pc;
    logic           alu;
    logic [OPW-1:0] op;
    logic           dv;
    logic [RW-1:0]  dst;
    logic           s0v;
    logic [RW-1:0]  s0;
    logic           s1v;
    logic [RW-1:0]  s1;
  } instr_t;

  function automatic chain_t chain_cat(chain_t a, chain_t b);
    chain_t r;
    int base;
    r = a;
    base = int'(a.len);
    for (int i = 0; i < CMAX; i++) begin
      if (i < int'(b.len) && (base + i) < CMAX) r.m[base + i] = b.m[i];
    end
    r.len = a.len + b.len;
    return r;
  endfunction
endpackage

// File: rtl/tcd_update.sv
module tcd_update
  import tcd_pkg::*;
(
  input  entry_t [NREG-1:0]  cur,
  input  instr_t             ins,
  output entry_t [NREG-1:0]  nxt,
  output chain_t [NEMIT-1:0] em,
  output logic   [NEMIT-1:0] em_v
);
  entry_t [NREG-1:0] t;
  entry_t            e;
  chain_t            single, merged, newc;
  logic [RW-1:0]     s, x;
  logic [1:0]        c;
  logic              take, chainable, self_rd, confirm;

  always_comb begin
    t = cur;
    em = '0;
    em_v = '0;
    take = 1'b0;
    s = '0;
    c = '0;
    single = '0;
    single.pc = ins.pc;
    single.len = LW'(1);
    single.m[0].op = ins.op;
    single.m[0].dst = ins.dst;
    single.m[0].s0 = ins.s0;
    single.m[0].s1 = ins.s1;
    chainable = ins.alu && ins.dv;

    // earlier single readers lose their output register: link can no longer form (R10)
    if (ins.dv) begin
      for (int r = 0; r < NREG; r++) begin
        if (t[r].cnt == 2'd1 && t[r].rd_dst == ins.dst) t[r].rd_ok = 1'b0;
      end
    end

    // read side: count readers, disqualify on second or non-chainable reader (R6, R7)
    for (int k = 0; k < 2; k++) begin
      if (k == 0) begin
        take = ins.s0v;
        s = ins.s0;
      end else begin
        take = ins.s1v && !(ins.s0v && ins.s1 == ins.s0);
        s = ins.s1;
      end
      if (take) begin
        c = t[s].cnt;
        if (c == 2'd0) begin
          t[s].rd_ok = chainable;
          t[s].rd_dst = ins.dst;
        end
        if (c != 2'd2) t[s].cnt = c + 2'd1;
        if (c != 2'd0 || !chainable) begin
          if (t[s].ch.len >= LW'(2)) begin
            em[k] = t[s].ch;
            em_v[k] = 1'b1;
          end
          t[s].ch = '0;
        end
      end
    end

    // write side: confirm transient or end the chain (R4, R5, R8, R9)
    e = t[ins.dst];
    x = e.rd_dst;
    self_rd = (x == ins.dst);
    merged = '0;
    confirm = 1'b0;
    newc = ins.alu ? single : '0;
    if (ins.dv) begin
      confirm = (e.ch.len != '0) && (e.cnt == 2'd1) && e.rd_ok &&
                (self_rd || t[x].ch.len == LW'(1));
      if (confirm) begin
        merged = chain_cat(e.ch, self_rd ? single : t[x].ch);
        if (merged.len == LW'(CMAX)) begin
          em[NEMIT-1] = merged;
          em_v[NEMIT-1] = 1'b1;
          if (self_rd) newc = '0;
          else t[x].ch = '0;
        end else if (self_rd) begin
          newc = merged;
        end else begin
          t[x].ch = merged;
        end
      end else if (e.ch.len >= LW'(2)) begin
        em[NEMIT-1] = e.ch;
        em_v[NEMIT-1] = 1'b1;
      end
      t[ins.dst].ch = newc;
      t[ins.dst].cnt = 2'd0;
      t[ins.dst].rd_ok = 1'b0;
      t[ins.dst].rd_dst = '0;
    end
    nxt = t;
  end
endmodule

// File: rtl/tcd_table.sv
module tcd_table
  import tcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  entry_t [NREG-1:0] nxt,
  output entry_t [NREG-1:0] cur
);
  always_ff @(posedge clk) begin
    if (!rst_n) cur <= '0;
    else if (we) cur <= nxt;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    // R5: a full chain never stays in the table
    a_r5_len_below_max: assert property (@(posedge clk) disable iff (!rst_n)
      cur[g].ch.len < LW'(CMAX));
    // R6: reader count saturates at two
    a_r6_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      cur[g].cnt != 2'd3);
  end
endmodule

// File: rtl/tcd_emit_buf.sv
module tcd_emit_buf
  import tcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  chain_t [NEMIT-1:0] em,
  input  logic   [NEMIT-1:0] em_v,
  input  logic               pop_ready,
  output chain_t             head,
  output logic               out_valid,
  output logic               empty
);
  chain_t [NEMIT-1:0] q, packed_q;
  logic   [CW-1:0]    cnt, np;

  // compact in fixed priority: source 0, source 1, overwrite (R11)
  always_comb begin
    packed_q = '0;
    np = '0;
    for (int k = 0; k < NEMIT; k++) begin
      if (em_v[k]) begin
        packed_q[np] = em[k];
        np = np + CW'(1);
      end
    end
  end

  assign out_valid = (cnt != '0);
  assign empty = (cnt == '0);
  assign head = q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
      cnt <= '0;
    end else if (load) begin
      q <= packed_q;
      cnt <= np;
    end else if (out_valid && pop_ready) begin
      for (int i = 0; i < NEMIT - 1; i++) q[i] <= q[i + 1];
      q[NEMIT-1] <= '0;
      cnt <= cnt - CW'(1);
    end
  end

  a_r3_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !pop_ready |=> out_valid && $stable(head));
  a_r12_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> head.len >= LW'(2) && head.len <= LW'(CMAX));
  a_r12_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && head.len == LW'(2) |-> head.m[CMAX-1] == '0);
endmodule

// File: rtl/transient_chain_detector.sv
module transient_chain_detector
  import tcd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [PCW-1:0]      in_pc,
  input  logic                in_alu,
  input  logic [OPW-1:0]      in_op,
  input  logic                in_dst_v,
  input  logic [RW-1:0]       in_dst,
  input  logic                in_src0_v,
  input  logic [RW-1:0]       in_src0,
  input  logic                in_src1_v,
  input  logic [RW-1:0]       in_src1,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PCW-1:0]      out_pc,
  output logic [LW-1:0]       out_len,
  output logic [CMAX*OPW-1:0] out_op,
  output logic [CMAX*RW-1:0]  out_dst,
  output logic [CMAX*RW-1:0]  out_src0,
  output logic [CMAX*RW-1:0]  out_src1
);
  instr_t             ins;
  entry_t [NREG-1:0]  cur, nxt;
  chain_t [NEMIT-1:0] em;
  logic   [NEMIT-1:0] em_v;
  chain_t             head;
  logic               empty, take;

  assign ins = '{pc: in_pc, alu: in_alu, op: in_op, dv: in_dst_v, dst: in_dst,
                 s0v: in_src0_v, s0: in_src0, s1v: in_src1_v, s1: in_src1};
  assign in_ready = empty;
  assign take = in_valid && in_ready;

  tcd_update u_update (.cur(cur), .ins(ins), .nxt(nxt), .em(em), .em_v(em_v));

  tcd_table u_table (.clk(clk), .rst_n(rst_n), .we(take), .nxt(nxt), .cur(cur));

  tcd_emit_buf u_buf (.clk(clk), .rst_n(rst_n), .load(take), .em(em), .em_v(em_v),
                      .pop_ready(out_ready), .head(head), .out_valid(out_valid),
                      .empty(empty));

  assign out_pc = head.pc;
  assign out_len = head.len;
  for (genvar k = 0; k < CMAX; k++) begin : g_out
    assign out_op[k*OPW +: OPW]  = head.m[k].op;
    assign out_dst[k*RW +: RW]   = head.m[k].dst;
    assign out_src0[k*RW +: RW]  = head.m[k].s0;
    assign out_src1[k*RW +: RW]  = head.m[k].s1;
  end

  a_r2_no_intake_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

// File: tb/transient_chain_detector_tb.sv
module transient_chain_detector_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_alu, in_dst_v, in_src0_v, in_src1_v;
  logic [31:0] in_pc;
  logic [3:0] in_op, in_dst, in_src0, in_src1;
  logic out_valid, out_ready;
  logic [31:0] out_pc;
  logic [1:0] out_len;
  logic [11:0] out_op, out_dst, out_src0, out_src1;

  int checks = 0;
  int errors = 0;
  logic [81:0] exp_q[$];
  string tag_q[$];
  logic [81:0] held;
  logic held_v = 1'b0;

  always #10 clk = ~clk;

  transient_chain_detector u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
    .in_alu(in_alu), .in_op(in_op), .in_dst_v(in_dst_v), .in_dst(in_dst),
    .in_src0_v(in_src0_v), .in_src0(in_src0), .in_src1_v(in_src1_v), .in_src1(in_src1),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc), .out_len(out_len),
    .out_op(out_op), .out_dst(out_dst), .out_src0(out_src0), .out_src1(out_src1));

  // member code m = {op, dst, src0, src1}, one nibble each
  task automatic send(input logic [31:0] pc, input logic alu, input logic [15:0] m);
    @(negedge clk);
    in_valid = 1'b1; in_pc = pc; in_alu = alu; in_op = m[15:12];
    in_dst_v = 1'b1; in_dst = m[11:8];
    in_src0_v = 1'b1; in_src0 = m[7:4]; in_src1_v = 1'b1; in_src1 = m[3:0];
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic expect_rec(input logic [31:0] pc, input logic [1:0] len,
                            input logic [15:0] m0, input logic [15:0] m1,
                            input logic [15:0] m2, input string tag);
    exp_q.push_back({pc, len, m2[15:12], m1[15:12], m0[15:12], m2[11:8], m1[11:8], m0[11:8],
                     m2[7:4], m1[7:4], m0[7:4], m2[3:0], m1[3:0], m0[3:0]});
    tag_q.push_back(tag);
  endtask

  task automatic check(input logic ok, input string req, input logic [81:0] act,
                       input logic [81:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and hold check (R3, R12)
  always @(negedge clk) begin
    logic [81:0] act, e;
    string tg;
    if (rst_n === 1'b1) begin
      act = {out_pc, out_len, out_op, out_dst, out_src0, out_src1};
      if (held_v) begin
        check(out_valid && act == held, "R3 record held under stall", act, held);
        held_v = 1'b0;
      end
      if (out_valid && !out_ready) begin
        held = act;
        held_v = 1'b1;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R12 unexpected record", act, '0);
        end else begin
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(act == e, {tg, " R12 record"}, act, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pc = '0; in_alu = 1'b0; in_op = '0;
    in_dst_v = 1'b0; in_dst = '0; in_src0_v = 1'b0; in_src0 = '0;
    in_src1_v = 1'b0; in_src1 = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", {81'd0, out_valid}, '0);
    check(in_ready == 1'b1, "R1 in_ready after reset", {81'd0, in_ready}, 82'd1);

    // R4 links and R5 three-member emission on the append
    expect_rec(32'h100, 2'd3, 16'h1112, 16'h1113, 16'h1914, "R5");
    send(32'h100, 1'b1, 16'h1112);
    send(32'h104, 1'b1, 16'h1113);
    send(32'h108, 1'b1, 16'h1914);
    send(32'h10c, 1'b1, 16'h2156);

    // R6: second reader of the tail ends a two-member chain
    expect_rec(32'h10c, 2'd2, 16'h2156, 16'h3210, 16'h0000, "R6");
    send(32'h200, 1'b1, 16'h3210);
    send(32'h204, 1'b1, 16'h1178);
    send(32'h208, 1'b1, 16'h4320);
    send(32'h20c, 1'b1, 16'h4420);

    // R7, R8, R11: one non-ALU instruction fires three emissions under stall
    send(32'h300, 1'b1, 16'h3500);
    send(32'h304, 1'b1, 16'h3550);
    send(32'h308, 1'b1, 16'h4600);
    send(32'h30c, 1'b1, 16'h4660);
    send(32'h310, 1'b1, 16'h5700);
    send(32'h314, 1'b1, 16'h5770);
    expect_rec(32'h300, 2'd2, 16'h3500, 16'h3550, 16'h0000, "R7 R11 src0");
    expect_rec(32'h308, 2'd2, 16'h4600, 16'h4660, 16'h0000, "R7 R11 src1");
    expect_rec(32'h310, 2'd2, 16'h5700, 16'h5770, 16'h0000, "R8 R11 overwrite");
    out_ready = 1'b0;
    send(32'h318, 1'b0, 16'h6756);
    @(negedge clk);
    check(out_valid == 1'b1 && in_ready == 1'b0, "R2 intake blocked while records wait",
          {80'd0, out_valid, in_ready}, 82'd2);
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R2 intake still blocked", {81'd0, in_ready}, '0);
    @(posedge clk);
    #1 out_ready = 1'b1;

    // R9: fan-in refused; the refused singleton is dropped (R8)
    expect_rec(32'h400, 2'd3, 16'h1800, 16'h2A89, 16'h3BA0, "R9");
    send(32'h400, 1'b1, 16'h1800);
    send(32'h404, 1'b1, 16'h1900);
    send(32'h408, 1'b1, 16'h2A89);
    send(32'h40c, 1'b1, 16'h1800);
    send(32'h410, 1'b1, 16'h1900);
    send(32'h414, 1'b1, 16'h3BA0);
    send(32'h418, 1'b1, 16'h1A00);

    // R10: reader's output overwritten first, so the producer chain ends alone
    expect_rec(32'h500, 2'd2, 16'h1C00, 16'h2CC0, 16'h0000, "R10");
    send(32'h500, 1'b1, 16'h1C00);
    send(32'h504, 1'b1, 16'h2CC0);
    send(32'h508, 1'b1, 16'h3DC0);
    send(32'h50c, 1'b1, 16'h4D00);
    send(32'h510, 1'b1, 16'h5C00);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 all expected records seen",
          82'(exp_q.size()), '0);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R2 idle after drain",
          {80'd0, out_valid, in_ready}, 82'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule